// File: doc/BRIEF.md
# Serial Display Byte Framer

This block turns bursts of command or data bytes into the three-wire synchronous serial stream that a graphic display controller expects. The wires are an active-high chip select, a serial clock that idles high, and a serial data line. The upstream logic opens a burst with a one-cycle start pulse that carries a mode flag, either command or data. It then hands over payload bytes one at a time on a valid/ready handshake. It closes the burst with an end request.

On the wire, every burst begins with a mode sync byte. Each payload byte is then sent as two wire bytes, and each of those carries one nibble in its upper four bits. Bits leave most significant first. For each bit the clock goes low, the data bit is placed during a separate setup phase, and the clock rises so the display samples the bit. Three parameters set the length in system clocks of the low, setup and high phases. A fourth parameter sets the settling gap. That gap follows chip select going high, each sync byte, and each payload byte.

Top module: `disp_byte_framer`

## Requirements
- R1: After reset, chip select is low, serial clock is high, busy is low and in_ready is low.
- R2: The first wire byte of a burst is 0xF8 when start_is_data was 0 at the start pulse, and 0xFA when it was 1.
- R3: Each accepted payload byte B goes out as two wire bytes: first B & 0xF0, then (B << 4) & 0xFF.
- R4: Each wire byte is shifted out most significant bit first. sdata changes only while sclk is low, so it is stable when sclk rises.
- R5: Within every bit, sclk stays low for LOW_CYC + SETUP_CYC clocks and then high for HIGH_CYC clocks. Between the two halves of a payload byte, the high time is exactly HIGH_CYC.
- R6: After chip select rises, sclk stays high for at least GAP_CYC clocks before its first falling edge.
- R7: After the last bit of a sync byte, and after the second half of each payload byte, sclk stays high for at least HIGH_CYC + GAP_CYC clocks before the next falling edge.
- R8: in_ready is high only while chip select is high, sclk is high and no byte or gap is in progress. A byte is taken when in_valid and in_ready are both high. in_ready is low in the next cycle.
- R9: While the block waits for a byte, end_req with in_valid low drops chip select on the next clock. busy stays high until chip select is low. A start pulse while busy is ignored and produces no extra sync byte.
- R10: sclk is high whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that opens a burst |
| start_is_data | input | 1 | Mode for the burst: 1 data, 0 command |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block can take a payload byte |
| end_req | input | 1 | Close the burst once idle between bytes |
| busy | output | 1 | Burst in progress (chip select high) |
| cs | output | 1 | Chip select, active high |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, sampled on rising sclk |

## Verification
A table of single-byte bursts alternates the two modes. The payloads are chosen so that the high and low nibbles differ (0xA5, 0x81, 0x3E), plus the all-ones and all-zero cases. This separates a swapped nibble order, a missing mask or shift, a reversed bit order and a wrong sync byte. A multi-byte data burst shows that the gap appears after each payload byte but not between its two halves. A start pulse issued in the middle of a burst must leave the wire stream unchanged. A bench-side monitor times every clock-low run, clock-high run and chip-select lead-in, so the phase lengths are checked independently of the decoded byte values.

// File: rtl/disp_byte_framer.sv
module disp_byte_framer #(
  parameter int LOW_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 2,
  parameter int GAP_CYC   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_is_data,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       end_req,
  output logic       busy,
  output logic       cs,
  output logic       sclk,
  output logic       sdata
);
  localparam int M1   = (LOW_CYC > SETUP_CYC) ? LOW_CYC : SETUP_CYC;
  localparam int M2   = (M1 > HIGH_CYC) ? M1 : HIGH_CYC;
  localparam int MAXC = (M2 > GAP_CYC) ? M2 : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [7:0] SYNC_CMD = 8'hF8;
  localparam logic [7:0] SYNC_DAT = 8'hFA;

  typedef enum logic [2:0] {S_IDLE, S_CSGAP, S_SHIFT, S_GAP, S_READY} st_t;

  st_t         st;
  logic        is_data, lo_pend, sdata_q;
  logic [7:0]  sh;
  logic [3:0]  lo_nib;
  logic [2:0]  bitn;
  logic [1:0]  ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ph_last;

  always_comb begin
    case (ph)
      2'd0:    ph_last = CW'(LOW_CYC - 1);
      2'd1:    ph_last = CW'(SETUP_CYC - 1);
      default: ph_last = CW'(HIGH_CYC - 1);
    endcase
  end

  wire gap_done = (cnt == CW'(GAP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; is_data <= 1'b0; lo_pend <= 1'b0; sdata_q <= 1'b0;
      sh <= '0; lo_nib <= '0; bitn <= '0; ph <= '0; cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          is_data <= start_is_data;
          cnt <= '0;
          st <= S_CSGAP;
        end
        S_CSGAP: if (gap_done) begin
          cnt <= '0;
          sh <= is_data ? SYNC_DAT : SYNC_CMD;
          lo_pend <= 1'b0; bitn <= '0; ph <= '0;
          st <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (cnt != ph_last) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          if (ph == 2'd0) begin
            ph <= 2'd1;
            sdata_q <= sh[7];
          end else if (ph == 2'd1) ph <= 2'd2;
          else begin
            ph <= 2'd0;
            sh <= {sh[6:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              if (lo_pend) begin
                sh <= {lo_nib, 4'h0};
                lo_pend <= 1'b0;
              end else st <= S_GAP;
            end
          end
        end
        S_GAP: if (gap_done) begin
          cnt <= '0;
          st <= S_READY;
        end else cnt <= cnt + 1'b1;
        S_READY: if (in_valid) begin
          sh <= {in_data[7:4], 4'h0};
          lo_nib <= in_data[3:0];
          lo_pend <= 1'b1; bitn <= '0; ph <= '0; cnt <= '0;
          st <= S_SHIFT;
        end else if (end_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cs       = (st != S_IDLE);
  assign busy     = cs;
  assign in_ready = (st == S_READY);
  assign sclk     = !(st == S_SHIFT && ph != 2'd2);
  assign sdata    = sdata_q;

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> sclk);
  assert_data_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk);
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cs && sclk));
  assert_accept_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_end_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && end_req) |=> (!cs && !busy));
endmodule

// File: tb/disp_byte_framer_bench.sv
`timescale 1ns/1ps
module disp_byte_framer_bench;
  localparam int LOW_CYC = 2, SETUP_CYC = 2, HIGH_CYC = 2, GAP_CYC = 10;
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h3E}, {1'b1, 8'hA5}, {1'b0, 8'h0C},
    {1'b1, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'h81}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_is_data = 1'b0, in_valid = 1'b0, end_req = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, cs, sclk, sdata;

  always #4 clk = ~clk;

  disp_byte_framer #(.LOW_CYC(LOW_CYC), .SETUP_CYC(SETUP_CYC),
    .HIGH_CYC(HIGH_CYC), .GAP_CYC(GAP_CYC)) u_disp_byte_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_is_data(start_is_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .end_req(end_req), .busy(busy), .cs(cs), .sclk(sclk), .sdata(sdata));

  int checks = 0, errors = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wire monitor
  logic [7:0] cap [64];
  int brun [64];
  int csg [64];
  int ncap = 0, bitpos = 0, run = 0, cs_cnt = 0, low_bad = 0, in_high_bad = 0;
  logic prev_sclk = 1'b1;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      prev_sclk = 1'b1; run = 0; cs_cnt = 0; bitpos = 0;
    end else begin
      if (sclk == prev_sclk) run++;
      else if (sclk) begin
        if (run != LOW_CYC + SETUP_CYC) low_bad++;
        acc = {acc[6:0], sdata};
        bitpos++;
        if (bitpos == 8) begin
          if (ncap < 64) cap[ncap] = acc;
          ncap++; bitpos = 0;
        end
        run = 1;
      end else begin
        if (bitpos != 0 && run != HIGH_CYC) in_high_bad++;
        if (bitpos == 0 && ncap < 64) begin
          brun[ncap] = run;
          csg[ncap] = cs_cnt;
        end
        run = 1;
      end
      prev_sclk = sclk;
      cs_cnt = cs ? cs_cnt + 1 : 0;
    end
  end

  task automatic open_burst(input logic dat);
    @(negedge clk); start = 1'b1; start_is_data = dat;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(negedge clk); in_valid = 1'b0;
    check(in_ready == 1'b0, "R8 ready low after accept", in_ready, 0);
  endtask

  task automatic close_burst();
    end_req = 1'b1;
    do @(negedge clk); while (busy);
    end_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({cs, sclk, busy, in_ready} == 4'b0100, "R1 reset state",
          {cs, sclk, busy, in_ready}, 4'b0100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({cs, sclk, busy, in_ready} == 4'b0100, "R1 idle after reset",
          {cs, sclk, busy, in_ready}, 4'b0100);

    for (int v = 0; v < NV; v++) begin
      automatic int base = ncap;
      automatic logic dat = VEC[v][8];
      automatic logic [7:0] b = VEC[v][7:0];
      automatic logic [7:0] sy = dat ? 8'hFA : 8'hF8;
      open_burst(dat);
      push(b);
      close_burst();
      check(ncap - base == 3, "R3 wire byte count", ncap - base, 3);
      check(cap[base] == sy, "R2 sync byte", cap[base], sy);
      check(cap[base+1] == (b & 8'hF0), "R3/R4 high nibble byte", cap[base+1], b & 8'hF0);
      check(cap[base+2] == {b[3:0], 4'h0}, "R3/R4 low nibble byte", cap[base+2], {b[3:0], 4'h0});
      check(csg[base] >= GAP_CYC, "R6 select lead-in", csg[base], GAP_CYC);
      check(brun[base+1] >= HIGH_CYC + GAP_CYC, "R7 gap after sync", brun[base+1], HIGH_CYC + GAP_CYC);
      check(brun[base+2] == HIGH_CYC, "R5 no gap inside split", brun[base+2], HIGH_CYC);
      check(cs == 1'b0 && busy == 1'b0, "R9 select dropped at end", {cs, busy}, 0);
    end

    // multi-byte data burst with a stray start while busy
    begin
      automatic int base = ncap;
      open_burst(1'b1);
      push(8'h5A);
      @(negedge clk); start = 1'b1; start_is_data = 1'b0;
      @(negedge clk); start = 1'b0;
      push(8'hC3);
      check(busy == 1'b1 && cs == 1'b1, "R9 busy while select high", {busy, cs}, 3);
      close_burst();
      check(ncap - base == 5, "R9 start ignored while busy", ncap - base, 5);
      check(cap[base] == 8'hFA, "R2 data sync", cap[base], 8'hFA);
      check(cap[base+3] == 8'hC0, "R3 second byte high", cap[base+3], 8'hC0);
      check(cap[base+4] == 8'h30, "R3 second byte low", cap[base+4], 8'h30);
      check(brun[base+3] >= HIGH_CYC + GAP_CYC, "R7 gap after payload", brun[base+3], HIGH_CYC + GAP_CYC);
    end

    // end_req is held off while a byte is in flight
    open_burst(1'b0);
    in_valid = 1'b1; in_data = 8'h12;
    do @(negedge clk); while (!in_ready);
    @(negedge clk); in_valid = 1'b0; end_req = 1'b1;
    repeat (4) @(negedge clk);
    check(cs == 1'b1, "R9 select held during byte", cs, 1);
    do @(negedge clk); while (busy);
    end_req = 1'b0;
    check(sclk == 1'b1 && cs == 1'b0, "R10 clock idles high", {sclk, cs}, 2);

    check(low_bad == 0, "R5 clock low length", low_bad, 0);
    check(in_high_bad == 0, "R5 clock high length", in_high_bad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule